// File: doc/BRIEF.md
# Reset and Strap Configuration Sequencer

This block decides how a multi-port switch comes out of reset. While the active-low global reset input is low, it holds the switch core and the management interface in reset. The release of that reset is passed through a synchroniser into the core clock domain. On the first core cycle after the release, the block samples the configuration straps once: the 4-bit switch mode code, the reference frequency select and the reset-halt request. It then runs a reset procedure of fixed length.

Some mode codes call for serial EEPROM initialisation. For these, the block sends a single-cycle start request to an external loader and waits for its done signal. A timeout guards that wait. If the halt strap was sampled high, the block then parks in a halted state. In that state the core stays in reset and the management buses run, so software can read and write registers. The block leaves the halted state when a management write clears the halt control bit. Reserved mode codes and loader timeouts put the block in a fault state that only a new global reset leaves. The decoded mode flags are presented as outputs for the rest of the switch.

Top module: `rstcfg_sequencer`

## Requirements
- R1: While `globalRstN` is low, `coreRstN`, `mgmtBusEn`, `loaderStart`, `halted`, both error flags and all decoded flags are 0, without waiting for a clock edge.
- R2: The straps are sampled once, in the first core cycle after the synchronised reset release. Strap changes after that have no effect on any output until the next global reset.
- R3: Mode decode, where an unlisted flag is 0:
  - 0x0: no flag set.
  - 0x1: `eepromInit`.
  - 0x8: `upstreamFixed`.
  - 0x9: `upstreamFixed` and `upstreamIsPort2`.
  - 0xA: `eepromInit` and `upstreamFixed`.
  - 0xB: `eepromInit`, `upstreamFixed` and `upstreamIsPort2`.
  - 0xC: `multiPartition`.
  - 0xD: `multiPartition` and `eepromInit`.
  - `clk125Sel` repeats the sampled frequency select, where 1 means 125 MHz and 0 means 100 MHz.
- R4: A reserved code (0x2 to 0x7, 0xE, 0xF) sets `modeError` and `halted` at the end of the procedure. In that case `coreRstN` stays 0 and no loader start is issued until the next global reset.
- R5: In an EEPROM mode, `loaderStart` is high for exactly one cycle. `coreRstN` stays 0 until `loaderDone` has been seen.
- R6: If `loaderDone` does not arrive within LOAD_TIMEOUT cycles of the wait, `loaderError` and `halted` are set. They remain set, with `coreRstN` at 0, until the next global reset, even if `loaderDone` arrives later.
- R7: In a non-EEPROM mode, `loaderStart` is never asserted.
- R8: With the halt strap sampled high, the block ends the procedure (including any EEPROM phase) with `halted` at 1 and `coreRstN` at 0. It stays there until a `haltClear` pulse, and `coreRstN` rises on the following edge.
- R9: With the halt strap sampled low and no error, `coreRstN` rises on its own once the procedure and any EEPROM phase are complete.
- R10: A `haltClear` pulse given before the halted state is reached has no effect: the block still halts.
- R11: `mgmtBusEn` rises in the first core cycle after the synchronised release. It stays high through the procedure, the EEPROM phase, the halted, fault and running states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| globalRstN | input | 1 | Asynchronous active-low global reset |
| modeStrap | input | 4 | Switch mode code strap |
| freqSelStrap | input | 1 | Reference frequency strap (1 = 125 MHz) |
| haltStrap | input | 1 | Reset-halt request strap |
| loaderDone | input | 1 | EEPROM loader completion |
| haltClear | input | 1 | Pulse: management write cleared the halt bit |
| coreRstN | output | 1 | Active-low reset to the switch core |
| mgmtBusEn | output | 1 | Management buses enabled |
| loaderStart | output | 1 | Single-cycle EEPROM loader request |
| halted | output | 1 | Parked in halt or fault |
| modeError | output | 1 | Reserved mode code sampled |
| loaderError | output | 1 | Loader timeout |
| eepromInit | output | 1 | Mode uses EEPROM initialisation |
| multiPartition | output | 1 | Multi-partition mode |
| upstreamFixed | output | 1 | Mode fixes the upstream port |
| upstreamIsPort2 | output | 1 | Upstream is port 2 (port 0 disabled); 0 with upstreamFixed means port 0 upstream (port 2 disabled) |
| clk125Sel | output | 1 | Sampled frequency select |

## Verification
The bench boots the block with every one of the 16 mode codes and alternates the frequency strap between boots. This separates the legal decodes from one another and from the reserved codes, and shows which codes involve the loader. EEPROM boots are driven in two ways: with a timely done, and with no done at all. These tell a correct single start pulse and wait apart from a premature release or a missing timeout. Halt boots use one clear given late and one given too early, which shows that only a clear in the halted state releases the core. Strap changes after sampling and a reset in mid-run test the one-time capture and the asynchronous reset path.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

  localparam int MODE_W = 4;

  typedef struct packed {
    logic reserved;
    logic eeprom;
    logic multi;
    logic upFixed;
    logic upPort2;
  } modeFlags_t;

  typedef struct packed {
    logic capture;
    logic procClr;
    logic procEn;
    logic toutClr;
    logic toutEn;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROC     = 3'd1,
    ST_LOADREQ  = 3'd2,
    ST_LOADWAIT = 3'd3,
    ST_HALT     = 3'd4,
    ST_RUN      = 3'd5,
    ST_FAULT    = 3'd6
  } seqState_t;

  function automatic modeFlags_t decodeMode(input logic [MODE_W-1:0] code);
    modeFlags_t f;
    f = '0;
    case (code)
      4'h0: ;
      4'h1: f.eeprom = 1'b1;
      4'h8: f.upFixed = 1'b1;
      4'h9: begin f.upFixed = 1'b1; f.upPort2 = 1'b1; end
      4'hA: begin f.eeprom = 1'b1; f.upFixed = 1'b1; end
      4'hB: begin f.eeprom = 1'b1; f.upFixed = 1'b1; f.upPort2 = 1'b1; end
      4'hC: f.multi = 1'b1;
      4'hD: begin f.multi = 1'b1; f.eeprom = 1'b1; end
      default: f.reserved = 1'b1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rstcfg_datapath.sv
module rstcfg_datapath
  import rstcfg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PROC_CYCLES  = 8,
  parameter int LOAD_TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              globalRstN,
  input  logic [MODE_W-1:0] modeStrap,
  input  logic              freqSelStrap,
  input  logic              haltStrap,
  input  seqStrobe_t        strobe,
  output logic              rstSyncN,
  output logic              procDone,
  output logic              toutExpired,
  output modeFlags_t        modeFlags,
  output logic              haltReq,
  output logic              freq125
);

  localparam int PCW = $clog2(PROC_CYCLES + 1);
  localparam int TCW = $clog2(LOAD_TIMEOUT + 1);
  localparam logic [PCW-1:0] PROC_LAST = PCW'(PROC_CYCLES - 1);
  localparam logic [TCW-1:0] TOUT_LAST = TCW'(LOAD_TIMEOUT - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [PCW-1:0]         procCnt;
  logic [TCW-1:0]         toutCnt;

  // release synchroniser: asserts asynchronously, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge globalRstN) begin
    if (!globalRstN) syncQ <= '0;
    else             syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstSyncN = syncQ[SYNC_STAGES-1];

  // one-time strap capture
  always_ff @(posedge clk or negedge globalRstN) begin
    if (!globalRstN) begin
      modeFlags <= '0;
      haltReq   <= 1'b0;
      freq125   <= 1'b0;
    end else if (strobe.capture) begin
      modeFlags <= decodeMode(modeStrap);
      haltReq   <= haltStrap;
      freq125   <= freqSelStrap;
    end
  end

  // fixed procedure length counter
  always_ff @(posedge clk or negedge globalRstN) begin
    if (!globalRstN)        procCnt <= '0;
    else if (strobe.procClr) procCnt <= '0;
    else if (strobe.procEn)  procCnt <= procCnt + 1'b1;
  end
  assign procDone = strobe.procEn && (procCnt == PROC_LAST);

  // loader wait timeout counter
  always_ff @(posedge clk or negedge globalRstN) begin
    if (!globalRstN)        toutCnt <= '0;
    else if (strobe.toutClr) toutCnt <= '0;
    else if (strobe.toutEn)  toutCnt <= toutCnt + 1'b1;
  end
  assign toutExpired = strobe.toutEn && (toutCnt == TOUT_LAST);

endmodule

// File: rtl/rstcfg_ctrl.sv
module rstcfg_ctrl
  import rstcfg_pkg::*;
(
  input  logic       clk,
  input  logic       globalRstN,
  input  logic       rstSyncN,
  input  logic       procDone,
  input  logic       toutExpired,
  input  modeFlags_t modeFlags,
  input  logic       haltReq,
  input  logic       loaderDone,
  input  logic       haltClear,
  output seqStrobe_t strobe,
  output logic       coreRstN,
  output logic       mgmtBusEn,
  output logic       loaderStart,
  output logic       halted,
  output logic       modeError,
  output logic       loaderError
);

  seqState_t stateQ, stateD;
  logic      setModeErr, setLoadErr;

  always_comb begin
    stateD     = stateQ;
    strobe     = '0;
    setModeErr = 1'b0;
    setLoadErr = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (rstSyncN) begin
          strobe.capture = 1'b1;
          strobe.procClr = 1'b1;
          stateD         = ST_PROC;
        end
      end
      ST_PROC: begin
        strobe.procEn = 1'b1;
        if (procDone) begin
          if (modeFlags.reserved) begin
            setModeErr = 1'b1;
            stateD     = ST_FAULT;
          end else if (modeFlags.eeprom) begin
            stateD = ST_LOADREQ;
          end else if (haltReq) begin
            stateD = ST_HALT;
          end else begin
            stateD = ST_RUN;
          end
        end
      end
      ST_LOADREQ: begin
        strobe.toutClr = 1'b1;
        stateD         = ST_LOADWAIT;
      end
      ST_LOADWAIT: begin
        strobe.toutEn = 1'b1;
        if (loaderDone) begin
          stateD = haltReq ? ST_HALT : ST_RUN;
        end else if (toutExpired) begin
          setLoadErr = 1'b1;
          stateD     = ST_FAULT;
        end
      end
      ST_HALT: begin
        if (haltClear) stateD = ST_RUN;
      end
      ST_RUN:   ;
      ST_FAULT: ;
      default:  stateD = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge globalRstN) begin
    if (!globalRstN) begin
      stateQ      <= ST_IDLE;
      modeError   <= 1'b0;
      loaderError <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (setModeErr) modeError   <= 1'b1;
      if (setLoadErr) loaderError <= 1'b1;
    end
  end

  assign coreRstN    = (stateQ == ST_RUN);
  assign mgmtBusEn   = (stateQ != ST_IDLE);
  assign loaderStart = (stateQ == ST_LOADREQ);
  assign halted      = (stateQ == ST_HALT) || (stateQ == ST_FAULT);

endmodule

// File: rtl/rstcfg_sequencer.sv
module rstcfg_sequencer
  import rstcfg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PROC_CYCLES  = 8,
  parameter int LOAD_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       globalRstN,
  input  logic [3:0] modeStrap,
  input  logic       freqSelStrap,
  input  logic       haltStrap,
  input  logic       loaderDone,
  input  logic       haltClear,
  output logic       coreRstN,
  output logic       mgmtBusEn,
  output logic       loaderStart,
  output logic       halted,
  output logic       modeError,
  output logic       loaderError,
  output logic       eepromInit,
  output logic       multiPartition,
  output logic       upstreamFixed,
  output logic       upstreamIsPort2,
  output logic       clk125Sel
);

  seqStrobe_t strobe;
  modeFlags_t modeFlags;
  logic       rstSyncN, procDone, toutExpired, haltReq;

  rstcfg_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .PROC_CYCLES (PROC_CYCLES),
    .LOAD_TIMEOUT(LOAD_TIMEOUT)
  ) u_dp (
    .clk         (clk),
    .globalRstN  (globalRstN),
    .modeStrap   (modeStrap),
    .freqSelStrap(freqSelStrap),
    .haltStrap   (haltStrap),
    .strobe      (strobe),
    .rstSyncN    (rstSyncN),
    .procDone    (procDone),
    .toutExpired (toutExpired),
    .modeFlags   (modeFlags),
    .haltReq     (haltReq),
    .freq125     (clk125Sel)
  );

  rstcfg_ctrl u_ctrl (
    .clk        (clk),
    .globalRstN (globalRstN),
    .rstSyncN   (rstSyncN),
    .procDone   (procDone),
    .toutExpired(toutExpired),
    .modeFlags  (modeFlags),
    .haltReq    (haltReq),
    .loaderDone (loaderDone),
    .haltClear  (haltClear),
    .strobe     (strobe),
    .coreRstN   (coreRstN),
    .mgmtBusEn  (mgmtBusEn),
    .loaderStart(loaderStart),
    .halted     (halted),
    .modeError  (modeError),
    .loaderError(loaderError)
  );

  assign eepromInit      = modeFlags.eeprom;
  assign multiPartition  = modeFlags.multi;
  assign upstreamFixed   = modeFlags.upFixed;
  assign upstreamIsPort2 = modeFlags.upPort2;

endmodule

// File: rtl/rstcfg_checker.sv
module rstcfg_checker (
  input logic       clk,
  input logic       globalRstN,
  input logic [3:0] modeStrap,
  input logic       freqSelStrap,
  input logic       haltStrap,
  input logic       loaderDone,
  input logic       haltClear,
  input logic       coreRstN,
  input logic       mgmtBusEn,
  input logic       loaderStart,
  input logic       halted,
  input logic       modeError,
  input logic       loaderError,
  input logic       eepromInit,
  input logic       multiPartition,
  input logic       upstreamFixed,
  input logic       upstreamIsPort2,
  input logic       clk125Sel
);

  p_core_held_r1: assert property (@(posedge clk)
    !globalRstN |-> (!coreRstN && !mgmtBusEn && !loaderStart));

  p_flags_frozen_r2: assert property (@(posedge clk) disable iff (!globalRstN)
    (mgmtBusEn && $past(mgmtBusEn)) |->
      ($stable(eepromInit) && $stable(multiPartition) && $stable(upstreamFixed)
       && $stable(upstreamIsPort2) && $stable(clk125Sel)));

  p_reserved_held_r4: assert property (@(posedge clk) disable iff (!globalRstN)
    modeError |-> (!coreRstN && halted && !loaderStart));

  p_start_single_r5: assert property (@(posedge clk) disable iff (!globalRstN)
    loaderStart |=> !loaderStart);

  p_load_err_sticky_r6: assert property (@(posedge clk) disable iff (!globalRstN)
    loaderError |=> (loaderError && !coreRstN));

  p_start_needs_eeprom_r7: assert property (@(posedge clk) disable iff (!globalRstN)
    loaderStart |-> eepromInit);

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (!globalRstN)
    (halted && !haltClear) |=> halted);

  p_mgmt_stays_r11: assert property (@(posedge clk) disable iff (!globalRstN)
    mgmtBusEn |=> mgmtBusEn);

endmodule

bind rstcfg_sequencer rstcfg_checker u_chk (.*);

// File: tb/test_rstcfg_sequencer.sv
`timescale 1ns/1ps
module test_rstcfg_sequencer;

  localparam int PROC_CYC = 8;
  localparam int TOUT     = 64;

  logic clk = 1'b0;
  logic globalRstN = 1'b0;
  logic [3:0] modeStrap = 4'h0;
  logic freqSelStrap = 1'b0, haltStrap = 1'b0, loaderDone = 1'b0, haltClear = 1'b0;
  logic coreRstN, mgmtBusEn, loaderStart, halted, modeError, loaderError;
  logic eepromInit, multiPartition, upstreamFixed, upstreamIsPort2, clk125Sel;

  int checks = 0, errors = 0, startCnt = 0;

  always #2.5 clk = ~clk;

  rstcfg_sequencer #(.SYNC_STAGES(2), .PROC_CYCLES(PROC_CYC), .LOAD_TIMEOUT(TOUT))
  i_rstcfg_sequencer (.*);

  always @(negedge clk) if (globalRstN && loaderStart) startCnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic boot(input logic [3:0] m, input logic f, input logic h);
    @(negedge clk);
    globalRstN = 1'b0;
    modeStrap = m; freqSelStrap = f; haltStrap = h;
    loaderDone = 1'b0; haltClear = 1'b0;
    repeat (3) @(negedge clk);
    globalRstN = 1'b1;
  endtask

  // wait up to n negedges for a condition selected by sel
  task automatic waitFor(input int sel, input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n && !seen; i++) begin
      @(negedge clk);
      case (sel)
        0: seen = coreRstN;
        1: seen = halted;
        2: seen = loaderStart;
        default: seen = mgmtBusEn;
      endcase
    end
  endtask

  function automatic logic [4:0] expFlags(input logic [3:0] m);
    // {reserved, eeprom, multi, upFixed, upPort2}
    case (m)
      4'h0: return 5'b00000;
      4'h1: return 5'b01000;
      4'h8: return 5'b00010;
      4'h9: return 5'b00011;
      4'hA: return 5'b01010;
      4'hB: return 5'b01011;
      4'hC: return 5'b00100;
      4'hD: return 5'b01100;
      default: return 5'b10000;
    endcase
  endfunction

  task automatic testResetState;
    @(negedge clk);
    globalRstN = 1'b0;
    repeat (2) @(negedge clk);
    chk({coreRstN, mgmtBusEn, loaderStart, halted, modeError, loaderError} == 6'b0,
        "R1", "outputs in reset", {coreRstN, mgmtBusEn, loaderStart, halted}, 0);
    chk({eepromInit, multiPartition, upstreamFixed, upstreamIsPort2, clk125Sel} == 5'b0,
        "R1", "flags in reset", eepromInit, 0);
  endtask

  task automatic testDecodeAll;
    bit seen;
    logic [4:0] e;
    int base;
    for (int c = 0; c < 16; c++) begin
      e = expFlags(4'(c));
      boot(4'(c), c[0], 1'b0);
      base = startCnt;
      if (e[3]) begin
        waitFor(2, 40, seen);
        @(negedge clk); loaderDone = 1'b1;
        @(negedge clk); loaderDone = 1'b0;
      end
      waitFor(0, 40, seen);
      chk({eepromInit, multiPartition, upstreamFixed, upstreamIsPort2} == e[3:0],
          "R3", $sformatf("flags code %0d", c),
          {eepromInit, multiPartition, upstreamFixed, upstreamIsPort2}, e[3:0]);
      chk(clk125Sel == c[0], "R3", "freq select", clk125Sel, c[0]);
      if (e[4]) begin
        chk(modeError && halted && !coreRstN, "R4", $sformatf("reserved %0d", c),
            {modeError, halted, coreRstN}, 3'b110);
        chk(startCnt == base, "R4", "no start on reserved", startCnt - base, 0);
      end else begin
        chk(coreRstN && !halted, "R9", $sformatf("runs code %0d", c), coreRstN, 1);
        if (!e[3]) chk(startCnt == base, "R7", "no loader start", startCnt - base, 0);
      end
    end
  endtask

  task automatic testLoaderPulse;
    bit seen;
    int base;
    boot(4'hA, 1'b0, 1'b0);
    base = startCnt;
    waitFor(2, 40, seen);
    chk(seen, "R5", "start seen", seen, 1);
    chk(mgmtBusEn, "R11", "mgmt on during loader phase", mgmtBusEn, 1);
    @(negedge clk);
    chk(!loaderStart, "R5", "start one cycle", loaderStart, 0);
    repeat (20) @(negedge clk);
    chk(!coreRstN, "R5", "core held while loading", coreRstN, 0);
    loaderDone = 1'b1;
    @(negedge clk); loaderDone = 1'b0;
    chk(coreRstN, "R5", "core released after done", coreRstN, 1);
    chk(startCnt - base == 1, "R5", "start count", startCnt - base, 1);
  endtask

  task automatic testTimeout;
    bit seen;
    boot(4'hD, 1'b1, 1'b0);
    waitFor(2, 40, seen);
    repeat (TOUT - 8) @(negedge clk);
    chk(!loaderError, "R6", "no early timeout", loaderError, 0);
    repeat (12) @(negedge clk);
    chk(loaderError && halted && !coreRstN, "R6", "timeout fault",
        {loaderError, halted, coreRstN}, 3'b110);
    loaderDone = 1'b1;
    repeat (3) @(negedge clk);
    loaderDone = 1'b0;
    chk(loaderError && !coreRstN, "R6", "late done ignored", coreRstN, 0);
    chk(mgmtBusEn, "R11", "mgmt on in fault", mgmtBusEn, 1);
  endtask

  task automatic testHalt;
    bit seen;
    boot(4'h1, 1'b0, 1'b1);
    waitFor(2, 40, seen);
    @(negedge clk); loaderDone = 1'b1;
    @(negedge clk); loaderDone = 1'b0;
    chk(halted && !coreRstN, "R8", "halted after load", {halted, coreRstN}, 2'b10);
    repeat (30) @(negedge clk);
    chk(halted && !coreRstN && mgmtBusEn, "R8", "still halted, mgmt on",
        {halted, coreRstN, mgmtBusEn}, 3'b101);
    haltClear = 1'b1;
    @(negedge clk); haltClear = 1'b0;
    chk(coreRstN && !halted, "R8", "released by clear", coreRstN, 1);
  endtask

  task automatic testEarlyClear;
    bit seen;
    boot(4'h0, 1'b0, 1'b1);
    waitFor(3, 10, seen);
    chk(seen && !coreRstN, "R11", "mgmt on before core", {mgmtBusEn, coreRstN}, 2'b10);
    haltClear = 1'b1;
    @(negedge clk); haltClear = 1'b0;
    waitFor(1, 20, seen);
    chk(seen && !coreRstN, "R10", "early clear ignored", halted, 1);
  endtask

  task automatic testStrapStatic;
    bit seen;
    boot(4'hC, 1'b0, 1'b0);
    waitFor(0, 30, seen);
    modeStrap = 4'hB; freqSelStrap = 1'b1; haltStrap = 1'b1;
    repeat (10) @(negedge clk);
    chk({eepromInit, multiPartition, upstreamFixed, upstreamIsPort2, clk125Sel} == 5'b01000,
        "R2", "flags unchanged", {eepromInit, multiPartition, upstreamFixed}, 3'b010);
    chk(coreRstN && !halted, "R2", "still running", coreRstN, 1);
  endtask

  task automatic testAsyncReset;
    @(negedge clk);
    globalRstN = 1'b0;
    #1;
    chk(!coreRstN && !mgmtBusEn && !multiPartition, "R1", "async reset",
        {coreRstN, mgmtBusEn, multiPartition}, 0);
  endtask

  initial begin
    #(5.0 * 60000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testDecodeAll();
    testLoaderPulse();
    testTimeout();
    testHalt();
    testEarlyClear();
    testStrapStatic();
    testAsyncReset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule